// File: doc/BRIEF.md
# Bitwise Logical Execution Unit

This block is the logical execution slice of a fixed-point processor pipeline. Each cycle it may accept one operation carrying two 64-bit register operands, a 16-bit immediate, an operation code, a record flag and the current summary-overflow bit. It returns the 64-bit result one cycle later. Alongside the result it returns a 4-bit condition field and a strobe that says whether that field must be written.

The operation set has three groups. The first is eight two-register boolean functions, including the inverted and complemented-operand forms. The second is six immediate forms: the 16-bit immediate is used either zero-extended or moved up by 16 bit positions with zeros below it. The third is three sign extensions, from a byte, a halfword or a word. Each operation has a fixed rule for the condition update. The register forms and the sign extensions follow the record flag. AND with an immediate always records. OR and XOR with an immediate never record.

The condition field is computed for every result, whatever the strobe says. It holds a signed comparison of the result against zero, plus a copy of the summary-overflow input.

Top module: `logic_exec_unit`

## Requirements
- R1: Codes 0 to 7 compute, from operands A and B: 0 A&B, 1 A|B, 2 A^B, 3 ~(A&B), 4 ~(A|B), 5 ~(A^B), 6 A&~B, 7 A|~B.
- R2: Codes 8, 9 and 10 compute A&I, A|I and A^I. Here I is the 16-bit immediate zero-extended to 64 bits, so immediate bit 15 never reaches bits 63:16.
- R3: Codes 11, 12 and 13 compute A&S, A|S and A^S. Here S holds the immediate in bits 31:16, with zeros in bits 15:0 and in bits 63:32.
- R4: Codes 14, 15 and 16 copy bits 7:0, 15:0 or 31:0 of A and fill every higher bit with A bit 7, 15 or 31 respectively.
- R5: Codes 17 to 31 give an all-zero result and never raise the condition-write strobe.
- R6: Codes 8 and 11 always raise the condition-write strobe. Codes 9, 10, 12 and 13 never raise it, whatever the record flag.
- R7: For codes 0 to 7 and 14 to 16, the condition-write strobe equals the record flag.
- R8: The condition field is {LT, GT, EQ, SO}, with LT in bit 3 and SO in bit 0. LT, GT and EQ are a signed comparison of the result with zero, exactly one of them is set, and SO copies the summary-overflow input.
- R9: Result, condition field and strobe appear on the outputs one clock after in_valid, with out_valid high. After a cycle without in_valid, out_valid and the strobe are low and the result holds. After reset, out_valid, the strobe and the result are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | An operation is presented this cycle |
| in_op | input | 5 | Operation code |
| in_rc | input | 1 | Record flag for the register and sign-extend forms |
| in_so | input | 1 | Summary-overflow bit copied into the condition field |
| opnd_a | input | 64 | First register operand |
| opnd_b | input | 64 | Second register operand |
| in_imm | input | 16 | Immediate field |
| out_valid | output | 1 | Outputs carry a new result |
| out_result | output | 64 | Registered result |
| out_cr_we | output | 1 | Condition field must be written |
| out_cr | output | 4 | Condition field {LT, GT, EQ, SO} |

## Verification
Every one of the 32 operation codes is swept over eight operand sets, with the record flag both low and high. The operand sets are all zeros, all ones, single high bits, alternating stripes and mixed words. They keep apart functions that agree on simple inputs, such as NAND against OR-with-complement. An immediate with bit 15 set separates zero extension from sign extension. The shifted form is told apart from the plain form by where the immediate lands. Operands with bit 7, 15 or 31 set but zero upper bits expose a sign extension taken from the wrong position. Results that are negative, positive and zero cover each condition bit. Idle cycles placed between operations test that the output holds.

// File: rtl/lu_pkg.sv
package lu_pkg;

  typedef enum logic [4:0] {
    OP_AND   = 5'd0,
    OP_OR    = 5'd1,
    OP_XOR   = 5'd2,
    OP_NAND  = 5'd3,
    OP_NOR   = 5'd4,
    OP_EQV   = 5'd5,
    OP_ANDC  = 5'd6,
    OP_ORC   = 5'd7,
    OP_ANDI  = 5'd8,
    OP_ORI   = 5'd9,
    OP_XORI  = 5'd10,
    OP_ANDIS = 5'd11,
    OP_ORIS  = 5'd12,
    OP_XORIS = 5'd13,
    OP_EXTB  = 5'd14,
    OP_EXTH  = 5'd15,
    OP_EXTW  = 5'd16
  } lu_op_e;

  typedef enum logic [2:0] {
    FN_AND  = 3'd0,
    FN_OR   = 3'd1,
    FN_XOR  = 3'd2,
    FN_NAND = 3'd3,
    FN_NOR  = 3'd4,
    FN_EQV  = 3'd5,
    FN_ANDC = 3'd6,
    FN_ORC  = 3'd7
  } lu_fn_e;

  typedef struct packed {
    logic lt;
    logic gt;
    logic eq;
    logic so;
  } lu_cr_t;

endpackage

// File: rtl/lu_logic_core.sv
module lu_logic_core
  import lu_pkg::*;
#(
  parameter int XLEN  = 64,
  parameter int IMM_W = 16
) (
  input  logic [4:0]       op,
  input  logic [XLEN-1:0]  a,
  input  logic [XLEN-1:0]  b,
  input  logic [IMM_W-1:0] imm,
  output logic [XLEN-1:0]  res,
  output logic             hit
);

  localparam int ZPAD_LO = XLEN - IMM_W;
  localparam int ZPAD_HI = XLEN - 2 * IMM_W;

  function automatic logic [XLEN-1:0] apply_fn(input lu_fn_e f,
                                              input logic [XLEN-1:0] x,
                                              input logic [XLEN-1:0] y);
    case (f)
      FN_AND:  return x & y;
      FN_OR:   return x | y;
      FN_XOR:  return x ^ y;
      FN_NAND: return ~(x & y);
      FN_NOR:  return ~(x | y);
      FN_EQV:  return ~(x ^ y);
      FN_ANDC: return x & ~y;
      default: return x | ~y;
    endcase
  endfunction

  logic [XLEN-1:0] imm_low;
  logic [XLEN-1:0] imm_up;
  logic [XLEN-1:0] opnd_y;
  lu_fn_e          fn;

  assign imm_low = {{ZPAD_LO{1'b0}}, imm};
  assign imm_up  = {{ZPAD_HI{1'b0}}, imm, {IMM_W{1'b0}}};

  always_comb begin
    fn     = FN_AND;
    opnd_y = b;
    hit    = 1'b1;
    case (op)
      OP_AND, OP_OR, OP_XOR, OP_NAND,
      OP_NOR, OP_EQV, OP_ANDC, OP_ORC: fn = lu_fn_e'(op[2:0]);
      OP_ANDI:  begin fn = FN_AND; opnd_y = imm_low; end
      OP_ORI:   begin fn = FN_OR;  opnd_y = imm_low; end
      OP_XORI:  begin fn = FN_XOR; opnd_y = imm_low; end
      OP_ANDIS: begin fn = FN_AND; opnd_y = imm_up;  end
      OP_ORIS:  begin fn = FN_OR;  opnd_y = imm_up;  end
      OP_XORIS: begin fn = FN_XOR; opnd_y = imm_up;  end
      default:  hit = 1'b0;
    endcase
  end

  assign res = hit ? apply_fn(fn, a, opnd_y) : '0;

endmodule

// File: rtl/lu_sign_ext.sv
module lu_sign_ext #(
  parameter int XLEN   = 64,
  parameter int BASE_W = 8,
  parameter int N_SRC  = 3
) (
  input  logic [$clog2(N_SRC)-1:0] sel,
  input  logic                     en,
  input  logic [XLEN-1:0]          a,
  output logic [XLEN-1:0]          res
);

  localparam int SEL_W = $clog2(N_SRC);

  logic [XLEN-1:0] ext [N_SRC];

  for (genvar k = 0; k < N_SRC; k++) begin : g_src
    localparam int SW = BASE_W << k;
    assign ext[k] = {{(XLEN-SW){a[SW-1]}}, a[SW-1:0]};
  end

  always_comb begin
    res = '0;
    for (int k = 0; k < N_SRC; k++) begin
      if (en && sel == SEL_W'(k)) res = ext[k];
    end
  end

endmodule

// File: rtl/lu_cond_gen.sv
module lu_cond_gen
  import lu_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic [XLEN-1:0] res,
  input  logic            so,
  output lu_cr_t          cr
);

  logic is_zero;
  assign is_zero = (res == '0);

  always_comb begin
    cr.lt = res[XLEN-1];
    cr.eq = is_zero;
    cr.gt = !res[XLEN-1] && !is_zero;
    cr.so = so;
  end

endmodule

// File: rtl/logic_exec_unit.sv
module logic_exec_unit
  import lu_pkg::*;
#(
  parameter int XLEN  = 64,
  parameter int IMM_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [4:0]       in_op,
  input  logic             in_rc,
  input  logic             in_so,
  input  logic [XLEN-1:0]  opnd_a,
  input  logic [XLEN-1:0]  opnd_b,
  input  logic [IMM_W-1:0] in_imm,
  output logic             out_valid,
  output logic [XLEN-1:0]  out_result,
  output logic             out_cr_we,
  output logic [3:0]       out_cr
);

  localparam int N_EXT = 3;
  localparam int EXT_SEL_W = $clog2(N_EXT);

  logic [XLEN-1:0]      core_res;
  logic                 core_hit;
  logic [XLEN-1:0]      ext_res;
  logic                 is_ext;
  logic [EXT_SEL_W-1:0] ext_sel;
  logic [4:0]           ext_idx;
  logic [XLEN-1:0]      result_d;
  logic                 upd_rule;
  logic                 rc_governed;
  logic                 op_unused;
  lu_cr_t               cr_d;

  lu_logic_core #(.XLEN(XLEN), .IMM_W(IMM_W)) u_core (
    .op (in_op), .a (opnd_a), .b (opnd_b), .imm (in_imm),
    .res(core_res), .hit(core_hit)
  );

  assign is_ext  = (in_op >= OP_EXTB) && (in_op <= OP_EXTW);
  assign ext_idx = in_op - OP_EXTB;
  assign ext_sel = ext_idx[EXT_SEL_W-1:0];

  lu_sign_ext #(.XLEN(XLEN), .BASE_W(8), .N_SRC(N_EXT)) u_ext (
    .sel(ext_sel), .en(is_ext), .a(opnd_a), .res(ext_res)
  );

  assign result_d  = core_hit ? core_res : ext_res;
  assign op_unused = !core_hit && !is_ext;

  always_comb begin
    rc_governed = 1'b0;
    upd_rule    = 1'b0;
    case (in_op)
      OP_AND, OP_OR, OP_XOR, OP_NAND, OP_NOR, OP_EQV, OP_ANDC, OP_ORC,
      OP_EXTB, OP_EXTH, OP_EXTW: begin rc_governed = 1'b1; upd_rule = in_rc; end
      OP_ANDI, OP_ANDIS:         upd_rule = 1'b1;
      default:                   upd_rule = 1'b0;
    endcase
  end

  lu_cond_gen #(.XLEN(XLEN)) u_cond (.res(result_d), .so(in_so), .cr(cr_d));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_result <= '0;
      out_cr_we  <= 1'b0;
      out_cr     <= '0;
    end else begin
      out_valid <= in_valid;
      out_cr_we <= in_valid && upd_rule;
      if (in_valid) begin
        out_result <= result_d;
        out_cr     <= cr_d;
      end
    end
  end

  p_valid_latency_r9: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  p_idle_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!out_valid && !out_cr_we && $stable(out_result)));
  p_unused_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op_unused) |=> (out_result == '0 && !out_cr_we));
  p_and_imm_update_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && (in_op == OP_ANDI || in_op == OP_ANDIS)) |=> out_cr_we);
  p_rc_follows_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && rc_governed) |=> (out_cr_we == $past(in_rc)));
  p_one_compare_r8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ($countones(out_cr[3:1]) == 1));
  p_sign_lt_r8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_cr[3] == out_result[XLEN-1]));

endmodule

// File: tb/logic_exec_unit_tb.sv
module logic_exec_unit_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [4:0]  in_op = '0;
  logic        in_rc = 1'b0;
  logic        in_so = 1'b0;
  logic [63:0] opnd_a = '0;
  logic [63:0] opnd_b = '0;
  logic [15:0] in_imm = '0;
  logic        out_valid;
  logic [63:0] out_result;
  logic        out_cr_we;
  logic [3:0]  out_cr;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  logic_exec_unit u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_op(in_op),
    .in_rc(in_rc), .in_so(in_so), .opnd_a(opnd_a), .opnd_b(opnd_b),
    .in_imm(in_imm), .out_valid(out_valid), .out_result(out_result),
    .out_cr_we(out_cr_we), .out_cr(out_cr)
  );

  task automatic chk(input bit ok, input string req,
                     input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] model(input int op, input logic [63:0] a,
                                        input logic [63:0] b, input logic [15:0] i);
    logic [63:0] zi = 64'(i);
    logic [63:0] si = 64'(i) << 16;
    case (op)
      0: return a & b;
      1: return a | b;
      2: return a ^ b;
      3: return ~a | ~b;
      4: return ~a & ~b;
      5: return (a & b) | (~a & ~b);
      6: return a & (b ^ 64'hFFFF_FFFF_FFFF_FFFF);
      7: return a | (b ^ 64'hFFFF_FFFF_FFFF_FFFF);
      8: return a & zi;
      9: return a | zi;
      10: return a ^ zi;
      11: return a & si;
      12: return a | si;
      13: return a ^ si;
      14: return 64'($signed(a << 56) >>> 56);
      15: return 64'($signed(a << 48) >>> 48);
      16: return 64'($signed(a << 32) >>> 32);
      default: return 64'd0;
    endcase
  endfunction

  function automatic string req_of(input int op);
    if (op <= 7) return "R1";
    if (op <= 10) return "R2";
    if (op <= 13) return "R3";
    if (op <= 16) return "R4";
    return "R5";
  endfunction

  logic [63:0] pa [8];
  logic [63:0] pb [8];
  logic [15:0] pi [8];

  initial begin
    pa[0] = 64'h0;                   pb[0] = 64'h0;                   pi[0] = 16'h0000;
    pa[1] = 64'hFFFF_FFFF_FFFF_FFFF; pb[1] = 64'hFFFF_FFFF_FFFF_FFFF; pi[1] = 16'hFFFF;
    pa[2] = 64'h0000_0000_0000_0080; pb[2] = 64'h8000_0000_0000_0000; pi[2] = 16'h8000;
    pa[3] = 64'h0000_0000_0000_8000; pb[3] = 64'hAAAA_AAAA_AAAA_AAAA; pi[3] = 16'h5555;
    pa[4] = 64'h0000_0000_8000_0000; pb[4] = 64'h5555_5555_5555_5555; pi[4] = 16'h00FF;
    pa[5] = 64'hAAAA_AAAA_AAAA_AAAA; pb[5] = 64'hF0F0_0F0F_3C3C_C3C3; pi[5] = 16'hA5A5;
    pa[6] = 64'h1234_5678_9ABC_DEF0; pb[6] = 64'h0FED_CBA9_8765_4321; pi[6] = 16'h8001;
    pa[7] = 64'h8000_0000_7FFF_FF7F; pb[7] = 64'h7FFF_FFFF_FFFF_FFFF; pi[7] = 16'h7FFF;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog R9 actual=%h expected=%h", 64'd0, 64'd1);
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    logic [63:0] exp_r;
    logic [63:0] held;
    logic        exp_we;
    logic [3:0]  exp_cr;
    int          vec;
    vec = 0;
    repeat (3) @(negedge clk);
    // R9: reset state
    chk(out_valid == 1'b0, "R9 reset valid", 64'(out_valid), 64'd0);
    chk(out_cr_we == 1'b0, "R9 reset strobe", 64'(out_cr_we), 64'd0);
    chk(out_result == 64'd0, "R9 reset result", out_result, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    for (int op = 0; op < 32; op++) begin
      for (int p = 0; p < 8; p++) begin
        for (int rc = 0; rc < 2; rc++) begin
          in_valid = 1'b1;
          in_op    = 5'(op);
          in_rc    = rc[0];
          in_so    = p[0] ^ rc[0];
          opnd_a   = pa[p];
          opnd_b   = pb[p];
          in_imm   = pi[p];
          exp_r  = model(op, pa[p], pb[p], pi[p]);
          if (op <= 7 || (op >= 14 && op <= 16)) exp_we = rc[0];   // R7
          else exp_we = (op == 8 || op == 11);                      // R6, R5
          exp_cr = {$signed(exp_r) < 0, $signed(exp_r) > 0, exp_r == 64'd0, p[0] ^ rc[0]};
          @(negedge clk);
          chk(out_valid == 1'b1, "R9 latency", 64'(out_valid), 64'd1);
          chk(out_result == exp_r, req_of(op), out_result, exp_r);
          if (op <= 7 || (op >= 14 && op <= 16))
            chk(out_cr_we == exp_we, "R7 strobe", 64'(out_cr_we), 64'(exp_we));
          else if (op <= 13)
            chk(out_cr_we == exp_we, "R6 strobe", 64'(out_cr_we), 64'(exp_we));
          else
            chk(out_cr_we == 1'b0, "R5 strobe", 64'(out_cr_we), 64'd0);
          chk(out_cr == exp_cr, "R8 condition", 64'(out_cr), 64'(exp_cr));
          vec++;
          if (vec % 5 == 0) begin
            held = out_result;
            in_valid = 1'b0;
            opnd_a = ~opnd_a;
            in_op = 5'd1;
            in_rc = 1'b1;
            @(negedge clk);
            chk(out_valid == 1'b0, "R9 idle valid", 64'(out_valid), 64'd0);
            chk(out_cr_we == 1'b0, "R9 idle strobe", 64'(out_cr_we), 64'd0);
            chk(out_result == held, "R9 idle hold", out_result, held);
          end
        end
      end
    end
    in_valid = 1'b0;
    @(negedge clk);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule